// File: doc/BRIEF.md
# Display Controller Control Register Bank

This block holds the control words of a display controller and hands their fields to the timing and pixel-formatting logic. Software reaches it through a simple synchronous read/write port. Every register answers at three write views. A plain write replaces the value. A set view ORs the written ones into the register. A clear view removes the written ones. With these views a single bit can be changed atomically, without a read-modify-write sequence.

There are two registers. The main control word holds run, the dot-clock and sync-mode selects, master, bus width, word length, clock gate and soft reset. The auxiliary word holds a 4-bit byte-lane valid mask and a self-clearing FIFO-clear request.

Switching dot-clock mode off while running does not stop the run flag at once. The flag stays set until the pixel FIFO reports empty, and only then reads back as zero. Soft reset holds every other field at zero for as long as it is set.

Top module: `dispctl_regbank`

## Requirements
- R1: A write to offset +0 of a register replaces its implemented bits with the written data.
- R2: A write to offset +4 sets every implemented bit written as one and leaves the others unchanged.
- R3: A write to offset +8 clears every bit written as one and leaves the others unchanged. A write to offset +0xC changes nothing.
- R4: The control word sits at 0x00. Its fields are run at bit 0, master at bit 5, word length at [9:8], bus width at [11:10], data select at bit 16, dot-clock mode at bit 17, sync mode at bit 18, bypass count at bit 19, clock gate at bit 30 and soft reset at bit 31. Every other bit reads as zero, and each field drives the output port of the same name.
- R5: The auxiliary word sits at 0x10, with the lane mask at [19:16]. Writing a one to bit 21 through the +0 or +4 view raises fifo_clr for exactly the cycle after the write. Bit 21 always reads as zero, and writing it through the +8 view raises no pulse.
- R6: When a write clears dot-clock mode while run and dot-clock mode are both set, run stays set. Run reads zero in the cycle after the first edge at which fifo_empty is sampled high.
- R7: While soft reset is set, every field other than soft reset and clock gate reads zero from the next cycle on, and writes to those fields are ignored. No FIFO-clear pulse is issued.
- R8: A read with rd_en returns the register value on rdata in the next cycle, taken before any write in the same cycle. The value comes back from any of the four offsets of a register. Reads of unmapped or unaligned addresses return zero, writes to them are ignored, and rdata is zero after a cycle without rd_en.
- R9: After reset every register, every output and rdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| fifo_empty | input | 1 | Pixel FIFO empty flag |
| rdata | output | 32 | Read data, one cycle after rd_en |
| run | output | 1 | Run flag |
| master | output | 1 | Bus master enable |
| word_len | output | 2 | Input word-length code |
| bus_width | output | 2 | Output bus-width code |
| data_sel | output | 1 | Data select |
| dotclk_mode | output | 1 | Dot-clock mode |
| vsync_mode | output | 1 | Sync-driven mode |
| bypass_cnt | output | 1 | Bypass count |
| clk_gate | output | 1 | Clock gate |
| soft_rst | output | 1 | Soft reset |
| lane_mask | output | 4 | Byte-lane valid mask |
| fifo_clr | output | 1 | One-cycle FIFO clear pulse |

## Verification
Every result of this block is due exactly one clock edge after its cause. Field outputs, lane mask and the FIFO-clear pulse change at the edge that takes the write. Read data appears at the edge that samples rd_en. The drain completion lowers run at the edge that samples fifo_empty high. The bench drives inputs on the falling edge, computes the expected state from the pre-edge model, and compares one nanosecond after the following rising edge, so every check lands in the cycle where the result is due.

// File: rtl/dispctl_regbank.sv
module dispctl_regbank #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              fifo_empty,
  output logic [31:0]       rdata,
  output logic              run,
  output logic              master,
  output logic [1:0]        word_len,
  output logic [1:0]        bus_width,
  output logic              data_sel,
  output logic              dotclk_mode,
  output logic              vsync_mode,
  output logic              bypass_cnt,
  output logic              clk_gate,
  output logic              soft_rst,
  output logic [3:0]        lane_mask,
  output logic              fifo_clr
);

  localparam int IDX_W = ADDR_W - 4;
  localparam logic [31:0] CTRL_MASK = 32'hC00F_0F21;
  localparam logic [31:0] AUX_MASK  = 32'h000F_0000;
  localparam logic [31:0] SRST_KEEP = 32'hC000_0000;
  localparam int CLR_BIT = 21;

  logic [31:0] ctrl_q, aux_q, ctrl_w, ctrl_d, aux_d, rdata_d;
  logic        drain_q, drain_d, clr_d;

  function automatic logic [31:0] merge(input logic [31:0] cur, input logic [31:0] d,
                                        input logic [1:0] v, input logic [31:0] m);
    case (v)
      2'b00:   return d & m;
      2'b01:   return (cur | d) & m;
      default: return cur & ~d & m;
    endcase
  endfunction

  wire             aligned  = (addr[1:0] == 2'b00);
  wire [1:0]       view     = addr[3:2];
  wire [IDX_W-1:0] idx      = addr[ADDR_W-1:4];
  wire             hit_ctrl = aligned && (idx == IDX_W'(0));
  wire             hit_aux  = aligned && (idx == IDX_W'(1));
  wire             wr_ok    = wr_en && (view != 2'b11);
  wire             in_srst  = ctrl_q[31];

  assign ctrl_w = (wr_ok && hit_ctrl) ? merge(ctrl_q, wdata, view, CTRL_MASK) : ctrl_q;

  wire drain_set  = ctrl_q[0] & ctrl_q[17] & ctrl_w[0] & ~ctrl_w[17];
  wire drain_done = drain_q & fifo_empty;

  always_comb begin
    ctrl_d    = ctrl_w;
    ctrl_d[0] = ctrl_w[0] & ~drain_done;
    if (in_srst) ctrl_d = ctrl_d & SRST_KEEP;
  end

  assign drain_d = ((drain_q & ~drain_done) | drain_set) & ctrl_d[0] & ~ctrl_d[17];

  assign aux_d = in_srst ? 32'd0 :
                 (wr_ok && hit_aux) ? merge(aux_q, wdata, view, AUX_MASK) : aux_q;

  assign clr_d = wr_ok && hit_aux && (view != 2'b10) && wdata[CLR_BIT] && !in_srst;

  assign rdata_d = !rd_en   ? 32'd0 :
                   hit_ctrl ? ctrl_q :
                   hit_aux  ? aux_q  : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      aux_q    <= '0;
      drain_q  <= 1'b0;
      fifo_clr <= 1'b0;
      rdata    <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      aux_q    <= aux_d;
      drain_q  <= drain_d;
      fifo_clr <= clr_d;
      rdata    <= rdata_d;
    end
  end

  assign run         = ctrl_q[0];
  assign master      = ctrl_q[5];
  assign word_len    = ctrl_q[9:8];
  assign bus_width   = ctrl_q[11:10];
  assign data_sel    = ctrl_q[16];
  assign dotclk_mode = ctrl_q[17];
  assign vsync_mode  = ctrl_q[18];
  assign bypass_cnt  = ctrl_q[19];
  assign clk_gate    = ctrl_q[30];
  assign soft_rst    = ctrl_q[31];
  assign lane_mask   = aux_q[19:16];

  p_clr_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |-> $past(wr_en && hit_aux && wdata[CLR_BIT]));

  p_drain_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !dotclk_mode && !fifo_empty && !wr_en && !soft_rst) |=> run);

  p_srst_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!run && !dotclk_mode && word_len == 2'b00 && lane_mask == 4'h0 && !fifo_clr));

  p_idle_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == 32'd0));

  p_dead_view_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[3:2] == 2'b11 && !soft_rst && !drain_q) |=> ($stable(ctrl_q) && $stable(aux_q)));

endmodule

// File: tb/dispctl_regbank_test.sv
`timescale 1ns/1ps
module dispctl_regbank_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, fifo_empty = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic run, master, data_sel, dotclk_mode, vsync_mode, bypass_cnt, clk_gate, soft_rst, fifo_clr;
  logic [1:0] word_len, bus_width;
  logic [3:0] lane_mask;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dispctl_regbank #(.ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .fifo_empty(fifo_empty), .rdata(rdata), .run(run), .master(master), .word_len(word_len),
    .bus_width(bus_width), .data_sel(data_sel), .dotclk_mode(dotclk_mode),
    .vsync_mode(vsync_mode), .bypass_cnt(bypass_cnt), .clk_gate(clk_gate),
    .soft_rst(soft_rst), .lane_mask(lane_mask), .fifo_clr(fifo_clr));

  logic [31:0] m_ctrl = 0, m_aux = 0;
  bit m_drain = 0;

  function automatic logic [31:0] obs_ctrl();
    logic [31:0] v = 0;
    v[0] = run; v[5] = master; v[9:8] = word_len; v[11:10] = bus_width;
    v[16] = data_sel; v[17] = dotclk_mode; v[18] = vsync_mode; v[19] = bypass_cnt;
    v[30] = clk_gate; v[31] = soft_rst;
    return v;
  endfunction

  function automatic logic [31:0] view_op(logic [31:0] cur, logic [31:0] d, logic [1:0] v, logic [31:0] m);
    if (v == 2'd0) return d & m;
    if (v == 2'd1) return (cur | d) & m;
    return cur & ~d & m;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit w, logic [7:0] a, logic [31:0] d, bit r, bit fe, string tag);
    logic [31:0] e_rd, nc, na;
    bit al, nclr, done, dset;
    logic [3:0] rg;
    logic [1:0] v;
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; rd_en = r; fifo_empty = fe;
    rg = a[7:4]; v = a[3:2]; al = (a[1:0] == 0);
    e_rd = !r ? 0 : (al && rg == 0) ? m_ctrl : (al && rg == 1) ? m_aux : 0;
    nc = m_ctrl; na = m_aux;
    if (w && al && v != 3 && rg == 0) nc = view_op(m_ctrl, d, v, 32'hC00F0F21);
    if (w && al && v != 3 && rg == 1) na = view_op(m_aux, d, v, 32'h000F0000);
    nclr = w && al && rg == 1 && (v == 0 || v == 1) && d[21] && !m_ctrl[31];
    done = m_drain && fe;
    dset = m_ctrl[0] && m_ctrl[17] && nc[0] && !nc[17];
    if (done) nc[0] = 0;
    if (m_ctrl[31]) begin nc &= 32'hC0000000; na = 0; end
    m_drain = ((m_drain && !done) || dset) && nc[0] && !nc[17];
    m_ctrl = nc; m_aux = na;
    @(posedge clk); #1;
    check(obs_ctrl() == m_ctrl, {tag, " R4 control fields"}, obs_ctrl(), m_ctrl);
    check(lane_mask == m_aux[19:16], {tag, " R5 lane mask"}, 32'(lane_mask), 32'(m_aux[19:16]));
    check(fifo_clr == nclr, {tag, " R5 fifo clear pulse"}, 32'(fifo_clr), 32'(nclr));
    check(rdata == e_rd, {tag, " R8 read data"}, rdata, e_rd);
    wr_en = 0; rd_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    check(obs_ctrl() == 0 && lane_mask == 0 && !fifo_clr && rdata == 0, "R9 reset state",
          obs_ctrl() | 32'(lane_mask), 0);
    @(negedge clk); rst_n = 1;

    step(1, 8'h00, 32'h7FFF_FFFF, 0, 0, "R1 plain write");
    check(obs_ctrl() == 32'h400F0F21, "R1 plain write value", obs_ctrl(), 32'h400F0F21);
    step(0, 8'h00, 0, 1, 0, "R8 read +0");
    check(rdata == 32'h400F0F21, "R8 read back", rdata, 32'h400F0F21);
    step(0, 8'h04, 0, 1, 0, "R8 read +4");
    step(0, 8'h0C, 0, 1, 0, "R8 read +C");
    step(1, 8'h08, 32'h4000_0F00, 0, 0, "R3 clear view");
    check(obs_ctrl() == 32'h000F0021, "R3 cleared bits", obs_ctrl(), 32'h000F0021);
    step(1, 8'h04, 32'h0000_0120, 0, 0, "R2 set view");
    check(obs_ctrl() == 32'h000F0121, "R2 set bits", obs_ctrl(), 32'h000F0121);
    step(1, 8'h0C, 32'hFFFF_FFFF, 0, 0, "R3 dead view");
    check(obs_ctrl() == 32'h000F0121, "R3 offset C ignored", obs_ctrl(), 32'h000F0121);

    step(1, 8'h10, 32'h002A_0000, 0, 0, "R5 fifo clear and lanes");
    check(fifo_clr && lane_mask == 4'hA, "R5 pulse issued", 32'(fifo_clr), 1);
    step(0, 8'h10, 0, 1, 0, "R5 pulse gone");
    check(!fifo_clr && rdata == 32'h000A0000, "R5 bit 21 reads zero", rdata, 32'h000A0000);
    step(1, 8'h18, 32'h0020_0000, 0, 0, "R5 clear view no pulse");
    check(!fifo_clr, "R5 no pulse via clear", 32'(fifo_clr), 0);

    step(1, 8'h00, 32'h0002_0001, 0, 0, "R6 start");
    step(1, 8'h08, 32'h0002_0000, 0, 0, "R6 drop dot mode");
    for (int i = 0; i < 4; i++) step(0, 8'h00, 0, 0, 0, "R6 draining");
    check(run == 1, "R6 run held while FIFO busy", 32'(run), 1);
    step(0, 8'h00, 0, 0, 1, "R6 FIFO empty");
    check(run == 0, "R6 run clears on empty", 32'(run), 0);

    step(1, 8'h20, 32'hFFFF_FFFF, 1, 0, "R8 unmapped");
    step(1, 8'h01, 32'h0000_0001, 1, 0, "R8 unaligned");
    check(run == 0, "R8 unaligned write ignored", 32'(run), 0);

    step(1, 8'h04, 32'h8000_0321, 0, 0, "R7 enter soft reset");
    step(1, 8'h14, 32'h002F_0000, 0, 0, "R7 writes ignored");
    step(0, 8'h00, 0, 1, 0, "R7 hold");
    check(obs_ctrl() == 32'h80000000 && lane_mask == 0, "R7 fields zero", obs_ctrl(), 32'h80000000);
    step(1, 8'h08, 32'h8000_0000, 0, 0, "R7 leave soft reset");

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      case ($urandom % 9)
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h10; 4: a = 8'h14;
        5: a = 8'h18; 6: a = 8'h0C; 7: a = 8'h30; default: a = 8'($urandom);
      endcase
      d = $urandom;
      if ($urandom % 24 != 0) d[31] = 0;
      if ($urandom % 2 == 0) d[17] = 1'b1 ^ d[17];
      step(($urandom % 3) != 0, a, d, ($urandom % 2) == 1, ($urandom % 4) == 0, "R1 R2 R3 random");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule